// File: doc/BRIEF.md
# Configuration Stream Command Parser

This block accepts a device configuration stream one byte at a time over a valid/ready handshake. It first insists on a fixed four-byte lead-in. It then hunts for a synchronization word, passing over filler bytes and any comment region on the way. After sync it decodes a command stream. Each command is an opcode followed by three parameter bytes and an opcode-dependent payload. Multi-byte payload values are big-endian.

Fixed 32-bit payloads load internal registers: control word 0, frame address, user code and bus address. One of them is instead compared against the expected device identity. Two commands open a bulk stream, one of configuration frames and one of bus words. Their payload bytes are forwarded downstream with a start strobe, a 16-bit count and the matching address, which steps once per frame or per word. A CRC-clear pulse, a sticky done flag and two sticky error flags complete the outputs. Once done or an error is raised, the parser stops accepting bytes until reset.

Top module: `cfg_stream_parser`

## Requirements
- R1: Out of reset, `inReady` is 1 and every register and flag output is 0. The first four accepted bytes must be 0x4C, 0x53, 0x43, 0x43. A mismatching byte sets `protoErr` and drops `inReady`.
- R2: Between the lead-in and sync, every byte has no effect on any register. This includes a comment region opened by 0xFF 0x00 and closed by 0x00 0xFF. A sync pattern inside a comment does not start decoding.
- R3: Decoding starts after the bytes 0xFF 0xFF 0xBD 0xB3, and any number of leading 0xFF bytes may come before them. While waiting for an opcode, a 0xFF byte is skipped as a dummy command with no parameters.
- R4: Opcodes 0x22, 0xC2, 0xF6 and 0xB4 take three parameter bytes and then a big-endian 32-bit payload. That payload loads `ctrlReg0`, `userCode`, `busAddr` and `frameAddr` respectively, and the new value is visible the cycle after the last payload byte is accepted.
- R5: Opcode 0xE2 compares its 32-bit payload with parameter EXPECTED_ID. On a mismatch it sets sticky `idError` and drops `inReady`. On a match decoding continues.
- R6: Opcode 0x46, with three parameter bytes and no payload, clears `frameAddr`.
- R7: For opcode 0x82, parameter bytes two and three form a big-endian frame count N.
  - When N is nonzero, `frameStart` pulses for one cycle with `frameCount`=N, the cycle after the third parameter byte.
  - The next N×(FRAME_BYTES+2) bytes each appear on `payData` with `frameValid` high the cycle after acceptance.
  - `frameAddr` increases by 1 after each frame's last byte.
- R8: For opcode 0x72, parameter bytes two and three form a big-endian word count N.
  - When N is nonzero, `busStart` pulses for one cycle with `busCount`=N.
  - The next N×WORD_BYTES bytes appear on `payData` with `busValid` high.
  - `busAddr` increases by 1 after each word.
- R9: A count of zero for 0x82 or 0x72 gives no start pulse and no payload. The next byte is decoded as an opcode.
- R10: Opcode 0x3B, with three parameter bytes, pulses `crcClear` for one cycle after its third parameter byte.
- R11: Opcode 0x5E, with three parameter bytes, sets sticky `done` and drops `inReady`. Later input changes no register.
- R12: Any opcode after sync other than those listed above sets sticky `protoErr` and drops `inReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte is present |
| inReady | output | 1 | Parser accepts a byte this cycle |
| ctrlReg0 | output | 32 | Control word 0 |
| frameAddr | output | 32 | Frame address counter |
| userCode | output | 32 | User code |
| busAddr | output | 32 | Bus word address |
| crcClear | output | 1 | One-cycle CRC accumulator clear |
| frameStart | output | 1 | Frame stream start pulse |
| frameCount | output | 16 | Frames in the current frame stream |
| frameValid | output | 1 | `payData` carries a frame byte |
| busStart | output | 1 | Bus stream start pulse |
| busCount | output | 16 | Words in the current bus stream |
| busValid | output | 1 | `payData` carries a bus byte |
| payData | output | 8 | Forwarded payload byte |
| idError | output | 1 | Sticky identity mismatch |
| protoErr | output | 1 | Sticky lead-in or opcode error |
| done | output | 1 | Sticky end of configuration |

## Verification
Every result is registered exactly once after the edge that accepts the byte causing it. This applies to register loads, address steps, start pulses, the CRC clear, flags and forwarded payload bytes. The bench therefore presents each byte for a single cycle and samples on the following falling edge, where that byte's effect, and only that byte's, must be visible. Stream lengths are swept from zero to three units for both frames and bus words. The expected addresses and byte values are computed arithmetically, and each forwarded byte is checked in the cycle right after it is sent.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  localparam logic [7:0] OP_DUMMY   = 8'hFF;
  localparam logic [7:0] OP_CRC_CLR = 8'h3B;
  localparam logic [7:0] OP_ID_CHK  = 8'hE2;
  localparam logic [7:0] OP_CTRL0   = 8'h22;
  localparam logic [7:0] OP_FA_CLR  = 8'h46;
  localparam logic [7:0] OP_FA_LOAD = 8'hB4;
  localparam logic [7:0] OP_FRAMES  = 8'h82;
  localparam logic [7:0] OP_USER    = 8'hC2;
  localparam logic [7:0] OP_BUS_ADR = 8'hF6;
  localparam logic [7:0] OP_BUS_WR  = 8'h72;
  localparam logic [7:0] OP_END     = 8'h5E;

  typedef enum logic [3:0] {
    S_LEAD, S_HUNT, S_FF1, S_FF2, S_FF3, S_CMT, S_CMT0,
    S_CMD, S_PARAM, S_WORD, S_STREAM, S_DONE, S_ERR
  } parseState_t;

  typedef struct packed {
    logic shiftIn;
    logic cntShift;
    logic startFrame;
    logic startBus;
    logic streamByte;
    logic loadCtrl0;
    logic loadFrameAddr;
    logic clrFrameAddr;
    logic loadUser;
    logic loadBusAddr;
    logic crcClr;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_parse_ctrl.sv
module cfg_parse_ctrl
  import cfg_stream_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       paramCntZero,
  input  logic       streamLast,
  input  logic       idMatch,
  output logic       inReady,
  output dpStrobe_t  stb,
  output logic       done,
  output logic       protoErr,
  output logic       idError
);

  parseState_t state, nState;
  logic [7:0]  opcode, nOpcode;
  logic [1:0]  idx, nIdx;
  logic        setProto, setId, setDone;
  logic        accept;

  function automatic logic [7:0] leadByte(input logic [1:0] i);
    case (i)
      2'd0:    leadByte = 8'h4C;
      2'd1:    leadByte = 8'h53;
      default: leadByte = 8'h43;
    endcase
  endfunction

  function automatic logic knownOp(input logic [7:0] op);
    knownOp = (op == OP_CRC_CLR) || (op == OP_ID_CHK) || (op == OP_CTRL0) ||
              (op == OP_FA_CLR) || (op == OP_FA_LOAD) || (op == OP_FRAMES) ||
              (op == OP_USER) || (op == OP_BUS_ADR) || (op == OP_BUS_WR) ||
              (op == OP_END);
  endfunction

  assign inReady = (state != S_DONE) && (state != S_ERR);
  assign accept  = inValid && inReady;

  always_comb begin
    nState   = state;
    nOpcode  = opcode;
    nIdx     = idx;
    stb      = '0;
    setProto = 1'b0;
    setId    = 1'b0;
    setDone  = 1'b0;
    if (accept) begin
      case (state)
        S_LEAD: begin
          if (inData == leadByte(idx)) begin
            nIdx = idx + 2'd1;
            if (idx == 2'd3) nState = S_HUNT;
          end else begin
            setProto = 1'b1;
            nState   = S_ERR;
          end
        end
        S_HUNT: if (inData == 8'hFF) nState = S_FF1;
        S_FF1: begin
          if (inData == 8'h00)      nState = S_CMT;
          else if (inData == 8'hFF) nState = S_FF2;
          else                      nState = S_HUNT;
        end
        S_FF2: begin
          if (inData == 8'hBD)      nState = S_FF3;
          else if (inData != 8'hFF) nState = S_HUNT;
        end
        S_FF3: begin
          if (inData == 8'hB3)      nState = S_CMD;
          else if (inData == 8'hFF) nState = S_FF1;
          else                      nState = S_HUNT;
        end
        S_CMT:  if (inData == 8'h00) nState = S_CMT0;
        S_CMT0: begin
          if (inData == 8'hFF)      nState = S_HUNT;
          else if (inData != 8'h00) nState = S_CMT;
        end
        S_CMD: begin
          if (inData != OP_DUMMY) begin
            if (knownOp(inData)) begin
              nOpcode = inData;
              nIdx    = 2'd0;
              nState  = S_PARAM;
            end else begin
              setProto = 1'b1;
              nState   = S_ERR;
            end
          end
        end
        S_PARAM: begin
          stb.cntShift = 1'b1;
          nIdx = idx + 2'd1;
          if (idx == 2'd2) begin
            nIdx = 2'd0;
            case (opcode)
              OP_FRAMES: begin
                stb.startFrame = !paramCntZero;
                nState = paramCntZero ? S_CMD : S_STREAM;
              end
              OP_BUS_WR: begin
                stb.startBus = !paramCntZero;
                nState = paramCntZero ? S_CMD : S_STREAM;
              end
              OP_CRC_CLR: begin
                stb.crcClr = 1'b1;
                nState = S_CMD;
              end
              OP_FA_CLR: begin
                stb.clrFrameAddr = 1'b1;
                nState = S_CMD;
              end
              OP_END: begin
                setDone = 1'b1;
                nState  = S_DONE;
              end
              default: nState = S_WORD;
            endcase
          end
        end
        S_WORD: begin
          stb.shiftIn = 1'b1;
          nIdx = idx + 2'd1;
          if (idx == 2'd3) begin
            nState = S_CMD;
            case (opcode)
              OP_ID_CHK: if (!idMatch) begin
                setId  = 1'b1;
                nState = S_ERR;
              end
              OP_CTRL0:   stb.loadCtrl0     = 1'b1;
              OP_FA_LOAD: stb.loadFrameAddr = 1'b1;
              OP_USER:    stb.loadUser      = 1'b1;
              default:    stb.loadBusAddr   = 1'b1;
            endcase
          end
        end
        S_STREAM: begin
          stb.streamByte = 1'b1;
          if (streamLast) nState = S_CMD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_LEAD;
      opcode   <= 8'h00;
      idx      <= 2'd0;
      done     <= 1'b0;
      protoErr <= 1'b0;
      idError  <= 1'b0;
    end else begin
      state  <= nState;
      opcode <= nOpcode;
      idx    <= nIdx;
      if (setDone)  done     <= 1'b1;
      if (setProto) protoErr <= 1'b1;
      if (setId)    idError  <= 1'b1;
    end
  end

  a_r11_done_blocks: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady);
  a_r12_proto_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
  a_r5_id_sticky: assert property (@(posedge clk) disable iff (!rstN)
    idError |=> (idError && !inReady));

endmodule

// File: rtl/cfg_parse_dpath.sv
module cfg_parse_dpath
  import cfg_stream_pkg::*;
#(
  parameter int          FRAME_BYTES = 4,
  parameter int          WORD_BYTES  = 4,
  parameter logic [31:0] EXPECTED_ID = 32'h1A2B3C4D
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  dpStrobe_t   stb,
  output logic        paramCntZero,
  output logic        streamLast,
  output logic        idMatch,
  output logic [31:0] ctrlReg0,
  output logic [31:0] frameAddr,
  output logic [31:0] userCode,
  output logic [31:0] busAddr,
  output logic        crcClear,
  output logic        frameStart,
  output logic [15:0] frameCount,
  output logic        frameValid,
  output logic        busStart,
  output logic [15:0] busCount,
  output logic        busValid,
  output logic [7:0]  payData
);

  localparam int FRAME_UNIT = FRAME_BYTES + 2;
  localparam int MAX_UNIT   = (FRAME_UNIT > WORD_BYTES) ? FRAME_UNIT : WORD_BYTES;
  localparam int UNIT_W     = $clog2(MAX_UNIT + 1);
  localparam logic [UNIT_W-1:0] FRAME_LAST = UNIT_W'(FRAME_UNIT - 1);
  localparam logic [UNIT_W-1:0] WORD_LAST  = UNIT_W'(WORD_BYTES - 1);

  logic [23:0]       shiftReg;
  logic [15:0]       cntReg;
  logic [31:0]       word;
  logic [15:0]       nextCnt;
  logic              isFrame;
  logic [15:0]       unitLeft;
  logic [UNIT_W-1:0] bytePos;
  logic              unitEnd;

  assign word         = {shiftReg, inData};
  assign nextCnt      = {cntReg[7:0], inData};
  assign paramCntZero = (nextCnt == 16'd0);
  assign idMatch      = (word == EXPECTED_ID);
  assign unitEnd      = (bytePos == (isFrame ? FRAME_LAST : WORD_LAST));
  assign streamLast   = unitEnd && (unitLeft == 16'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      cntReg     <= '0;
      isFrame    <= 1'b0;
      unitLeft   <= '0;
      bytePos    <= '0;
      ctrlReg0   <= '0;
      frameAddr  <= '0;
      userCode   <= '0;
      busAddr    <= '0;
      crcClear   <= 1'b0;
      frameStart <= 1'b0;
      frameCount <= '0;
      frameValid <= 1'b0;
      busStart   <= 1'b0;
      busCount   <= '0;
      busValid   <= 1'b0;
      payData    <= '0;
    end else begin
      crcClear   <= stb.crcClr;
      frameStart <= stb.startFrame;
      busStart   <= stb.startBus;
      frameValid <= stb.streamByte && isFrame;
      busValid   <= stb.streamByte && !isFrame;
      if (stb.streamByte) payData <= inData;
      if (stb.shiftIn)  shiftReg <= word[23:0];
      if (stb.cntShift) cntReg   <= nextCnt;
      if (stb.loadCtrl0) ctrlReg0 <= word;
      if (stb.loadUser)  userCode <= word;
      if (stb.startFrame || stb.startBus) begin
        isFrame  <= stb.startFrame;
        unitLeft <= nextCnt;
        bytePos  <= '0;
      end
      if (stb.startFrame) frameCount <= nextCnt;
      if (stb.startBus)   busCount   <= nextCnt;
      if (stb.streamByte) begin
        if (unitEnd) begin
          bytePos  <= '0;
          unitLeft <= unitLeft - 16'd1;
        end else begin
          bytePos <= bytePos + UNIT_W'(1);
        end
      end
      if (stb.clrFrameAddr)       frameAddr <= '0;
      else if (stb.loadFrameAddr) frameAddr <= word;
      else if (stb.streamByte && isFrame && unitEnd) frameAddr <= frameAddr + 32'd1;
      if (stb.loadBusAddr) busAddr <= word;
      else if (stb.streamByte && !isFrame && unitEnd) busAddr <= busAddr + 32'd1;
    end
  end

  a_r7_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    !(frameValid && busValid));
  a_r7_frame_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  a_r8_bus_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> !busStart);
  a_r10_crc_pulse: assert property (@(posedge clk) disable iff (!rstN)
    crcClear |=> !crcClear);

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfg_stream_pkg::*;
#(
  parameter int          FRAME_BYTES = 4,
  parameter int          WORD_BYTES  = 4,
  parameter logic [31:0] EXPECTED_ID = 32'h1A2B3C4D
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  logic        inValid,
  output logic        inReady,
  output logic [31:0] ctrlReg0,
  output logic [31:0] frameAddr,
  output logic [31:0] userCode,
  output logic [31:0] busAddr,
  output logic        crcClear,
  output logic        frameStart,
  output logic [15:0] frameCount,
  output logic        frameValid,
  output logic        busStart,
  output logic [15:0] busCount,
  output logic        busValid,
  output logic [7:0]  payData,
  output logic        idError,
  output logic        protoErr,
  output logic        done
);

  dpStrobe_t stb;
  logic      paramCntZero, streamLast, idMatch;

  cfg_parse_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .inValid      (inValid),
    .paramCntZero (paramCntZero),
    .streamLast   (streamLast),
    .idMatch      (idMatch),
    .inReady      (inReady),
    .stb          (stb),
    .done         (done),
    .protoErr     (protoErr),
    .idError      (idError)
  );

  cfg_parse_dpath #(
    .FRAME_BYTES (FRAME_BYTES),
    .WORD_BYTES  (WORD_BYTES),
    .EXPECTED_ID (EXPECTED_ID)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .stb          (stb),
    .paramCntZero (paramCntZero),
    .streamLast   (streamLast),
    .idMatch      (idMatch),
    .ctrlReg0     (ctrlReg0),
    .frameAddr    (frameAddr),
    .userCode     (userCode),
    .busAddr      (busAddr),
    .crcClear     (crcClear),
    .frameStart   (frameStart),
    .frameCount   (frameCount),
    .frameValid   (frameValid),
    .busStart     (busStart),
    .busCount     (busCount),
    .busValid     (busValid),
    .payData      (payData)
  );

endmodule

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;

  localparam int          FB  = 4;
  localparam int          WB  = 4;
  localparam logic [31:0] EID = 32'h1A2B3C4D;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] ctrlReg0, frameAddr, userCode, busAddr;
  logic        crcClear, frameStart, frameValid, busStart, busValid;
  logic [15:0] frameCount, busCount;
  logic [7:0]  payData;
  logic        idError, protoErr, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cfg_stream_parser #(.FRAME_BYTES(FB), .WORD_BYTES(WB), .EXPECTED_ID(EID)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .ctrlReg0(ctrlReg0), .frameAddr(frameAddr), .userCode(userCode), .busAddr(busAddr),
    .crcClear(crcClear), .frameStart(frameStart), .frameCount(frameCount),
    .frameValid(frameValid), .busStart(busStart), .busCount(busCount),
    .busValid(busValid), .payData(payData), .idError(idError),
    .protoErr(protoErr), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    inData  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [15:0] cnt);
    sendByte(op);
    sendByte(8'h00);
    sendByte(cnt[15:8]);
    sendByte(cnt[7:0]);
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) sendByte(w[i*8 +: 8]);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic leadAndSync();
    sendByte(8'h4C); sendByte(8'h53); sendByte(8'h43); sendByte(8'h43);
    sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hBD); sendByte(8'hB3);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] fa;
    logic [31:0] ba;
    doReset();
    // R1 reset state
    check("R1 ready", {31'd0, inReady}, 32'd1);
    check("R1 regs", ctrlReg0 | frameAddr | userCode | busAddr, 32'd0);
    check("R1 flags", {29'd0, done, protoErr, idError}, 32'd0);

    // R1 bad lead-in
    sendByte(8'h4C); sendByte(8'h00);
    check("R1 bad lead err", {31'd0, protoErr}, 32'd1);
    check("R1 bad lead ready", {31'd0, inReady}, 32'd0);

    doReset();
    sendByte(8'h4C); sendByte(8'h53); sendByte(8'h43); sendByte(8'h43);
    // R2 filler and a would-be command before sync are ignored
    sendByte(8'h12); sendByte(8'h34);
    sendCmd(8'h22, 16'h0000); sendWord(32'hAABBCCDD);
    // R2 comment containing a sync pattern
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h61);
    sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hBD); sendByte(8'hB3);
    sendCmd(8'hC2, 16'h0000); sendWord(32'h55667788);
    sendByte(8'h00); sendByte(8'hFF);
    check("R2 ctrl untouched", ctrlReg0, 32'd0);
    check("R2 user untouched", userCode, 32'd0);
    check("R2 no error", {31'd0, protoErr}, 32'd0);

    // R3 sync with an extra leading 0xFF, then a dummy
    sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hBD); sendByte(8'hB3);
    sendByte(8'hFF);
    // R10 CRC clear pulse
    sendCmd(8'h3B, 16'h0000);
    check("R10 crc pulse", {31'd0, crcClear}, 32'd1);
    @(negedge clk);
    check("R10 crc pulse ends", {31'd0, crcClear}, 32'd0);
    check("R3 decoding live", {31'd0, protoErr}, 32'd0);

    // R5 matching identity
    sendCmd(8'hE2, 16'h0000); sendWord(EID);
    check("R5 id match", {30'd0, idError, inReady}, 32'd1);

    // R4 word loads
    sendCmd(8'h22, 16'h0000); sendWord(32'h01020304);
    check("R4 ctrl0", ctrlReg0, 32'h01020304);
    sendCmd(8'hC2, 16'h0000); sendWord(32'hCAFE0042);
    check("R4 user", userCode, 32'hCAFE0042);
    sendCmd(8'hF6, 16'h0000); sendWord(32'h00002000);
    check("R4 busaddr", busAddr, 32'h00002000);
    sendCmd(8'hB4, 16'h0000); sendWord(32'h00000100);
    check("R4 frameaddr", frameAddr, 32'h00000100);

    // R7 / R9 frame stream sweep
    fa = 32'h100;
    for (int n = 0; n < 4; n++) begin
      sendCmd(8'h82, 16'(n));
      check(n == 0 ? "R9 no frame start" : "R7 frame start", {31'd0, frameStart}, (n == 0) ? 32'd0 : 32'd1);
      if (n != 0) check("R7 frame count", {16'd0, frameCount}, n);
      for (int f = 0; f < n; f++) begin
        for (int k = 0; k < FB + 2; k++) begin
          sendByte(8'((n * 64) + (f * 8) + k));
          check("R7 frame byte", {23'd0, frameValid, payData}, {23'd0, 1'b1, 8'((n * 64) + (f * 8) + k)});
        end
        fa = fa + 1;
        check("R7 frame addr step", frameAddr, fa);
      end
    end
    // R6 clear frame address
    sendCmd(8'h46, 16'h0000);
    check("R6 frameaddr cleared", frameAddr, 32'd0);

    // R8 / R9 bus stream sweep
    ba = 32'h2000;
    for (int n = 0; n < 4; n++) begin
      sendCmd(8'h72, 16'(n));
      check(n == 0 ? "R9 no bus start" : "R8 bus start", {31'd0, busStart}, (n == 0) ? 32'd0 : 32'd1);
      if (n != 0) check("R8 bus count", {16'd0, busCount}, n);
      for (int w = 0; w < n; w++) begin
        for (int k = 0; k < WB; k++) begin
          sendByte(8'(200 - (n * 16) - (w * 4) - k));
          check("R8 bus byte", {23'd0, busValid, payData}, {23'd0, 1'b1, 8'(200 - (n * 16) - (w * 4) - k)});
        end
        ba = ba + 1;
        check("R8 bus addr step", busAddr, ba);
      end
    end

    // R11 end command
    sendCmd(8'h5E, 16'h0000);
    check("R11 done", {30'd0, done, inReady}, 32'd2);
    sendCmd(8'hC2, 16'h0000); sendWord(32'h0BADF00D);
    check("R11 later input ignored", userCode, 32'hCAFE0042);

    // R5 identity mismatch
    doReset();
    leadAndSync();
    sendCmd(8'hE2, 16'h0000); sendWord(EID ^ 32'h1);
    check("R5 id mismatch", {30'd0, idError, inReady}, 32'd2);

    // R12 unknown opcode
    doReset();
    leadAndSync();
    sendByte(8'h99);
    check("R12 unknown opcode", {30'd0, protoErr, inReady}, 32'd2);
    sendCmd(8'h22, 16'h0000); sendWord(32'h11111111);
    check("R12 halted", ctrlReg0, 32'd0);

    summary();
  end

endmodule